// File: doc/BRIEF.md
# Two-Level Interrupt Selector

This block looks at the hart's current privilege, its global interrupt enable and a handful of pending sources, and decides whether an interrupt is to be taken now and under which cause code. The sources fall into two groups. The machine group holds a machine software-interrupt pending bit and a host mailbox word that counts as pending whenever it is nonzero. The supervisor group holds a supervisor software-interrupt pending bit and a supervisor timer that needs both its pending bit and its own enable.

A group may interrupt when the hart runs below that group's level. When the hart runs at exactly that level, the group may interrupt only if the global enable is set. Inside a group the software source wins over the other one. Any machine-group request beats any supervisor-group request.

The result is purely combinational. The pipeline samples it at an instruction boundary and then redirects. Saving the privilege stack and computing the trap vector are done elsewhere.

Top module: `intsel_top`

## Requirements
- R1: Privilege is coded 0 = user, 1 = supervisor, 3 = machine, and 2 sits numerically between supervisor and machine. The machine group may interrupt when the privilege code is below 3, or when it equals 3 and the global enable is 1.
- R2: Within the machine group, a set machine software pending bit is taken with identifier 0 ahead of the host mailbox, which is taken with identifier 2.
- R3: The host mailbox counts as pending when any one of its bits is 1, including only the top bit. An all-zero mailbox never raises a request.
- R4: The supervisor group may interrupt when the privilege code is below 1, or when it equals 1 and the global enable is 1. At codes 2 and 3 it never interrupts.
- R5: Within the supervisor group, a set supervisor software pending bit is taken with identifier 0 ahead of the timer, which is taken with identifier 1.
- R6: The timer raises a request only when its pending bit and its enable are both 1.
- R7: When both groups have an allowed request, the machine group's identifier is reported.
- R8: When an interrupt is taken, take_o is 1 and cause_o has its most significant bit set, the identifier in its low bits and zeros elsewhere. Otherwise take_o is 0 and cause_o is all zero.
- R9: The outputs follow the inputs within the same cycle. No input value is held over from an earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_i | input | 2 | Current privilege code (0 user, 1 supervisor, 3 machine) |
| gie_i | input | 1 | Global interrupt enable |
| msw_pend_i | input | 1 | Machine software interrupt pending |
| host_mbox_i | input | MBOX_W | Host mailbox word; pending when nonzero |
| ssw_pend_i | input | 1 | Supervisor software interrupt pending |
| stmr_pend_i | input | 1 | Supervisor timer pending |
| stmr_en_i | input | 1 | Supervisor timer interrupt enable |
| take_o | output | 1 | An interrupt is to be taken now |
| cause_o | output | XLEN | Cause word: interrupt flag in MSB, identifier in low bits |

## Verification
The hardest case to reach is a set of conditions where both groups have pending sources and the supervisor group is also open. Only then does the machine-over-supervisor order become visible, and that needs user privilege or supervisor privilege with the enable set, together with a machine source. A second hard case is the unused privilege code 2, where the machine group is open with the enable cleared while the supervisor group stays closed. The bench reaches both through a directed vector table. It then sweeps every combination of privilege, enable and the single-bit sources, and compares each result against its own reference model. Separate directed cases drive a mailbox with only its top bit set and a full-width cause check.

// File: rtl/intsel_pkg.sv
package intsel_pkg;

  localparam int PRIV_W = 2;

  localparam logic [PRIV_W-1:0] LVL_USER  = 2'd0;
  localparam logic [PRIV_W-1:0] LVL_SUPV  = 2'd1;
  localparam logic [PRIV_W-1:0] LVL_MACH  = 2'd3;

  localparam int SRC_ID_W = 2;

  localparam logic [SRC_ID_W-1:0] SRC_SOFT  = 2'd0;
  localparam logic [SRC_ID_W-1:0] SRC_TIMER = 2'd1;
  localparam logic [SRC_ID_W-1:0] SRC_HOST  = 2'd2;

  // A group at level lvl is open when the hart runs below it, or at it with the enable set.
  function automatic logic level_open(input logic [PRIV_W-1:0] cur,
                                      input logic [PRIV_W-1:0] lvl,
                                      input logic              gie);
    return (cur < lvl) || ((cur == lvl) && gie);
  endfunction

endpackage

// File: rtl/intsel_gate.sv
module intsel_gate
  import intsel_pkg::*;
#(
  parameter logic [PRIV_W-1:0] GROUP_LVL = LVL_MACH
) (
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              gie_i,
  output logic              open_o
);

  assign open_o = level_open(priv_i, GROUP_LVL, gie_i);

endmodule

// File: rtl/intsel_pick.sv
module intsel_pick #(
  parameter int N_SRC = 2,
  parameter int ID_W  = 2,
  parameter logic [N_SRC*ID_W-1:0] SRC_IDS = '0
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [ID_W-1:0]  id_o
);

  // Slot 0 has the highest rank; scan from the lowest rank upward so slot 0 overwrites.
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        hit_o = 1'b1;
        id_o  = SRC_IDS[k*ID_W +: ID_W];
      end
    end
  end

endmodule

// File: rtl/intsel_top.sv
module intsel_top
  import intsel_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int MBOX_W = 16
) (
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              gie_i,
  input  logic              msw_pend_i,
  input  logic [MBOX_W-1:0] host_mbox_i,
  input  logic              ssw_pend_i,
  input  logic              stmr_pend_i,
  input  logic              stmr_en_i,
  output logic              take_o,
  output logic [XLEN-1:0]   cause_o
);

  localparam int GRP_SRCS = 2;
  localparam logic [GRP_SRCS*SRC_ID_W-1:0] M_IDS = {SRC_HOST,  SRC_SOFT};
  localparam logic [GRP_SRCS*SRC_ID_W-1:0] S_IDS = {SRC_TIMER, SRC_SOFT};

  function automatic logic [XLEN-1:0] build_cause(input logic             fire,
                                                  input logic [SRC_ID_W-1:0] id);
    logic [XLEN-1:0] w;
    w = '0;
    if (fire) begin
      w[XLEN-1]       = 1'b1;
      w[SRC_ID_W-1:0] = id;
    end
    return w;
  endfunction

  // Named internal events
  logic                m_open, s_open;
  logic                host_nz, tmr_req;
  logic                m_hit, s_hit;
  logic [SRC_ID_W-1:0] m_id, s_id;
  logic                m_fire, s_fire;
  logic [SRC_ID_W-1:0] win_id;

  assign host_nz = |host_mbox_i;
  assign tmr_req = stmr_pend_i & stmr_en_i;

  intsel_gate #(.GROUP_LVL(LVL_MACH)) u_gate_m (
    .priv_i (priv_i),
    .gie_i  (gie_i),
    .open_o (m_open)
  );

  intsel_gate #(.GROUP_LVL(LVL_SUPV)) u_gate_s (
    .priv_i (priv_i),
    .gie_i  (gie_i),
    .open_o (s_open)
  );

  intsel_pick #(.N_SRC(GRP_SRCS), .ID_W(SRC_ID_W), .SRC_IDS(M_IDS)) u_pick_m (
    .req_i ({host_nz, msw_pend_i}),
    .hit_o (m_hit),
    .id_o  (m_id)
  );

  intsel_pick #(.N_SRC(GRP_SRCS), .ID_W(SRC_ID_W), .SRC_IDS(S_IDS)) u_pick_s (
    .req_i ({tmr_req, ssw_pend_i}),
    .hit_o (s_hit),
    .id_o  (s_id)
  );

  assign m_fire = m_open & m_hit;
  assign s_fire = s_open & s_hit;
  assign win_id = m_fire ? m_id : s_id;

  assign take_o  = m_fire | s_fire;
  assign cause_o = build_cause(take_o, win_id);

  // Checks on the settled outputs
  always_comb begin
    p_cause_flag_r8: assert (take_o == cause_o[XLEN-1])
      else $error("cause flag disagrees with take strobe");
    if (!take_o) begin
      p_idle_zero_r8: assert (cause_o == '0)
        else $error("cause word not zero while idle");
    end
    if (priv_i == LVL_MACH && !gie_i) begin
      p_mach_closed_r1: assert (!take_o)
        else $error("interrupt taken in machine mode with enable clear");
    end
    if (priv_i >= 2'd2) begin
      p_supv_shut_r4: assert (!s_open)
        else $error("supervisor group open above supervisor");
    end
    if (m_fire) begin
      p_mach_first_r7: assert (cause_o[SRC_ID_W-1:0] == m_id)
        else $error("machine group did not win");
    end
    if (m_fire && msw_pend_i) begin
      p_msw_first_r2: assert (cause_o[SRC_ID_W-1:0] == SRC_SOFT)
        else $error("machine software not first");
    end
    if (take_o && cause_o[SRC_ID_W-1:0] == SRC_TIMER) begin
      p_timer_en_r6: assert (stmr_pend_i && stmr_en_i)
        else $error("timer taken without pending and enable");
    end
  end

endmodule

// File: tb/tb_intsel_top.sv
module tb_intsel_top;

  localparam int XLEN   = 64;
  localparam int MBOX_W = 16;

  logic              clk;
  logic [1:0]        priv_i;
  logic              gie_i, msw_pend_i, ssw_pend_i, stmr_pend_i, stmr_en_i;
  logic [MBOX_W-1:0] host_mbox_i;
  logic              take_o;
  logic [XLEN-1:0]   cause_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  intsel_top #(.XLEN(XLEN), .MBOX_W(MBOX_W)) dut (
    .priv_i(priv_i), .gie_i(gie_i), .msw_pend_i(msw_pend_i),
    .host_mbox_i(host_mbox_i), .ssw_pend_i(ssw_pend_i),
    .stmr_pend_i(stmr_pend_i), .stmr_en_i(stmr_en_i),
    .take_o(take_o), .cause_o(cause_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Vector: {priv[1:0], gie, msw, host, ssw, stmr_pend, stmr_en, exp_take, exp_id[1:0]}
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R1 closed at M
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0}, // R1 open at M
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2}, // R2 host
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0}, // R2 order
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}, // R4 shut at M
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 closed at S
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0}, // R4 open at S
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2}, // R1 below M
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1}, // R6 timer
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R6 no enable
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R6 no pending
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1}, // R4 below S
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0}, // R5 order
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2}, // R7 machine wins
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0}, // R5 order at S
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}  // R4 code 2
  };

  function automatic logic [XLEN-1:0] want_cause(input logic t, input logic [1:0] id);
    logic [XLEN-1:0] c;
    c = '0;
    if (t) c = {1'b1, {(XLEN-3){1'b0}}, id};
    return c;
  endfunction

  // Independent reference, written per privilege code
  task automatic ref_model(input logic [1:0] p, input logic g, input logic ms,
                           input logic hn, input logic ss, input logic tp, input logic te,
                           output logic t, output logic [1:0] id);
    logic mok, sok;
    case (p)
      2'd0: begin mok = 1; sok = 1; end
      2'd1: begin mok = 1; sok = g; end
      2'd2: begin mok = 1; sok = 0; end
      default: begin mok = g; sok = 0; end
    endcase
    t = 0; id = 0;
    if (mok && ms)             begin t = 1; id = 0; end
    else if (mok && hn)        begin t = 1; id = 2; end
    else if (sok && ss)        begin t = 1; id = 0; end
    else if (sok && tp && te)  begin t = 1; id = 1; end
  endtask

  task automatic apply(input logic [1:0] p, input logic g, input logic ms,
                       input logic [MBOX_W-1:0] hb, input logic ss,
                       input logic tp, input logic te);
    @(negedge clk);
    priv_i = p; gie_i = g; msw_pend_i = ms; host_mbox_i = hb;
    ssw_pend_i = ss; stmr_pend_i = tp; stmr_en_i = te;
    #2;
  endtask

  task automatic check(input string req, input logic et, input logic [1:0] eid);
    logic [XLEN-1:0] ec;
    ec = want_cause(et, eid);
    n_cmp++;
    if (take_o !== et || cause_o !== ec) begin
      n_bad++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
               req, take_o, cause_o, et, ec);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    priv_i = 0; gie_i = 0; msw_pend_i = 0; host_mbox_i = '0;
    ssw_pend_i = 0; stmr_pend_i = 0; stmr_en_i = 0;

    // Quiet state: nothing pending
    apply(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    check("R8 quiet", 1'b0, 2'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][10:9], VEC[v][8], VEC[v][7],
            {{(MBOX_W-1){1'b0}}, VEC[v][6]}, VEC[v][5], VEC[v][4], VEC[v][3]);
      check($sformatf("R1-table vec%0d", v), VEC[v][2], VEC[v][1:0]);
    end

    // R3: only top mailbox bit set
    apply(2'd3, 1'b1, 1'b0, {1'b1, {(MBOX_W-1){1'b0}}}, 1'b0, 1'b0, 1'b0);
    check("R3 top bit", 1'b1, 2'd2);
    // R3: empty mailbox at open machine level
    apply(2'd3, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    check("R3 empty", 1'b0, 2'd0);
    // R3: scattered mailbox pattern
    apply(2'd0, 1'b0, 1'b0, 16'h0A50, 1'b0, 1'b1, 1'b1);
    check("R3 R7 pattern", 1'b1, 2'd2);

    // R9: back-to-back change within consecutive cycles
    apply(2'd1, 1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
    check("R9 step a", 1'b1, 2'd0);
    apply(2'd1, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    check("R9 step b", 1'b0, 2'd0);

    // Exhaustive sweep of single-bit inputs against the reference
    for (int c = 0; c < 512; c++) begin
      logic [8:0] b;
      logic et;
      logic [1:0] eid;
      b = c[8:0];
      apply(b[8:7], b[6], b[5], b[4] ? 16'h0100 : 16'h0000, b[3], b[2], b[1]);
      ref_model(b[8:7], b[6], b[5], b[4], b[3], b[2], b[1], et, eid);
      check($sformatf("R7 sweep %0d", c), et, eid);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule